// File: doc/BRIEF.md
# Top-Octave Tone Divider Bank

This block produces twelve square waves, one for each semitone of the highest octave of a keyboard, from a single shared reference. Every clock cycle that carries the tick enable counts as one half-rate tick. Each channel divides that tick stream by its own fixed ratio. Lower octaves are usually made from these outputs by chains of divide-by-two stages further along the signal path.

Each channel holds a down-counter that is loaded with a half-period count. When the counter runs out, the channel flips its output and loads the count for the next half. An even full-period divisor N gives two equal halves of N/2 ticks. An odd divisor gives a high half of floor(N/2) ticks and a low half that is one tick longer, so that the full period is still exactly N ticks. The divisors are compile-time parameters and cannot be changed at run time.

Top module: `top_octave_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `tone` becomes 0 after that edge, and every channel restarts its first half-period.
- R2: On a clock edge where `tick_en` is low, `tone` does not change.
- R3: After reset, the first change of each channel is a rise to 1. It occurs on the edge that consumes that channel's floor(N/2)-th tick.
- R4: Every high half of channel i lasts exactly floor(N/2) ticks, where N is the divisor of that channel.
- R5: Every low half after the first one lasts exactly N - floor(N/2) ticks, so each full period spans N ticks.
- R6: The channels with odd divisors are bits 0, 1, 4, 5, 8 and 11, and their low half is one tick longer than their high half. All other channels have equal halves.
- R7: Bit i of `tone` belongs to the channel with the i-th default divisor in this list: 239, 253, 268, 284, 301, 319, 338, 358, 379, 402, 426, 451. Bit 0 is therefore the highest note.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One half-rate reference tick per cycle in which it is high |
| tone | output | 12 | Registered square-wave outputs, one bit per channel |

## Verification
A counter in the wrong state or a reload of the wrong half shows at the ports as a single half-period that is too long or too short. This is seen at the very next transition of that channel, which comes at most about 226 ticks later. A swap between the two reload values of an odd channel turns its high/low pair around, and this shows within one full period. Counting on idle cycles shows as an edge that arrives early during stretches with a sparse tick pattern. The bench measures every half-period of every channel over four periods, on a tick stream that has gaps, and compares each one with the expected pair for that channel.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int unsigned NUM_TONES = 12;
  localparam int unsigned CNT_W     = 9;

  // Full-period divisors in half-rate ticks, highest note first
  localparam int unsigned TOP_DIVS [NUM_TONES] = '{
    239, 253, 268, 284, 301, 319, 338, 358, 379, 402, 426, 451
  };

  function automatic int unsigned high_ticks(input int unsigned n);
    return n / 2;
  endfunction

  function automatic int unsigned low_ticks(input int unsigned n);
    return n - (n / 2);
  endfunction

endpackage

// File: rtl/half_period_sel.sv
module half_period_sel #(
  parameter int unsigned DIV = 239,
  parameter int unsigned CW  = 9
) (
  output logic [CW-1:0] hi_cnt,
  output logic [CW-1:0] lo_cnt
);

  localparam int unsigned HI = tone_pkg::high_ticks(DIV);

  assign hi_cnt = CW'(HI);

  generate
    if (DIV % 2 == 0) begin : g_sym
      assign lo_cnt = CW'(HI);
    end else begin : g_asym
      assign lo_cnt = CW'(HI + 1);
    end
  endgenerate

endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int unsigned DIV = 239,
  parameter int unsigned CW  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic tone_o
);

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] remain;
  logic          last_tick;

  half_period_sel #(.DIV(DIV), .CW(CW)) u_sel (
    .hi_cnt (hi_cnt),
    .lo_cnt (lo_cnt)
  );

  // The tick that takes the counter down to zero ends the half-period
  assign last_tick = (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= hi_cnt;
      tone_o <= 1'b0;
    end else if (tick_en) begin
      if (last_tick) begin
        tone_o <= ~tone_o;
        // Going high loads the high count, going low loads the low count
        remain <= tone_o ? lo_cnt : hi_cnt;
      end else begin
        remain <= remain - CW'(1);
      end
    end
  end

endmodule

// File: rtl/top_octave_bank.sv
module top_octave_bank #(
  parameter int unsigned NCH        = tone_pkg::NUM_TONES,
  parameter int unsigned CW         = tone_pkg::CNT_W,
  parameter int unsigned DIVS [NCH] = tone_pkg::TOP_DIVS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_en,
  output logic [NCH-1:0] tone
);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      tone_channel #(.DIV(DIVS[g]), .CW(CW)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .tone_o  (tone[g])
      );
    end
  endgenerate

endmodule

// File: rtl/top_octave_bank_chk.sv
module top_octave_bank_chk #(
  parameter int unsigned NCH        = tone_pkg::NUM_TONES,
  parameter int unsigned CW         = tone_pkg::CNT_W,
  parameter int unsigned DIVS [NCH] = tone_pkg::TOP_DIVS
) (
  input logic           clk,
  input logic           rst,
  input logic           tick_en,
  input logic [NCH-1:0] tone
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (tone == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(tone));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_len
      localparam logic [CW:0] HI = (CW+1)'(tone_pkg::high_ticks(DIVS[g]));
      localparam logic [CW:0] LO = (CW+1)'(tone_pkg::low_ticks(DIVS[g]));
      logic [CW:0] run;
      logic        tq;
      logic        first;

      always_ff @(posedge clk) begin
        if (rst) begin
          run   <= '0;
          tq    <= 1'b0;
          first <= 1'b1;
        end else begin
          tq  <= tone[g];
          run <= ((tone[g] != tq) ? '0 : run) + {{CW{1'b0}}, tick_en};
          if (tone[g] && !tq) first <= 1'b0;
        end
      end

      // R3
      first_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (tone[g] && !tq && first) |-> (run == HI));

      // R4
      high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!tone[g] && tq) |-> (run == HI));

      // R5
      low_len_chk: assert property (@(posedge clk) disable iff (rst)
        (tone[g] && !tq && !first) |-> (run == LO));
    end
  endgenerate

endmodule

bind top_octave_bank top_octave_bank_chk #(.NCH(NCH), .CW(CW), .DIVS(DIVS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .tone    (tone)
);

// File: tb/test_top_octave_bank.sv
module test_top_octave_bank;

  localparam int NCH = 12;
  // Expected {high, low} half-periods in ticks per channel (R4, R5, R6)
  localparam int EXP_HL [NCH][2] = '{
    '{119, 120}, '{126, 127}, '{134, 134}, '{142, 142},
    '{150, 151}, '{159, 160}, '{169, 169}, '{179, 179},
    '{189, 190}, '{201, 201}, '{213, 213}, '{225, 226}
  };
  localparam int SEGS = 9;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick_en = 1'b0;
  logic [NCH-1:0] tone;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  top_octave_bank i_top_octave_bank (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .tone    (tone)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t);
    tick_en = t;
    @(negedge clk);
  endtask

  initial begin
    int ticks;
    int idle_bad;
    int last [NCH];
    int seg [NCH];
    logic [NCH-1:0] prev;

    @(negedge clk);
    rst = 1'b1;
    repeat (2) step(1'b0);
    rst = 1'b0;
    chk(tone == '0, "R1 reset value", int'(tone), 0);

    repeat (300) step(1'b0);
    chk(tone == '0, "R2 idle cycles", int'(tone), 0);

    repeat (118) step(1'b1);
    chk(tone == '0, "R3 before first expiry", int'(tone), 0);
    step(1'b1);
    chk(tone == 12'h001, "R3 first rise of channel 0", int'(tone), 1);
    chk(tone[0] == 1'b1, "R7 bit 0 is the 239 channel", int'(tone[0]), 1);
    repeat (20) step(1'b0);
    chk(tone == 12'h001, "R2 held with no ticks", int'(tone), 1);

    rst = 1'b1;
    step(1'b1);
    rst = 1'b0;
    chk(tone == '0, "R1 mid-run reset", int'(tone), 0);

    ticks = 0;
    idle_bad = 0;
    prev = tone;
    for (int c = 0; c < NCH; c++) begin
      last[c] = 0;
      seg[c]  = 0;
    end

    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit t;
      t = ((cyc % 4) != 3);
      step(t);
      if (t) ticks++;
      if (!t && (tone != prev)) idle_bad++;
      for (int c = 0; c < NCH; c++) begin
        if (tone[c] != prev[c] && seg[c] < SEGS) begin
          int len;
          int exp;
          len = ticks - last[c];
          if (seg[c] == 0 || (seg[c] % 2) == 1) exp = EXP_HL[c][0];
          else exp = EXP_HL[c][1];
          if (seg[c] == 0)
            chk(len == exp && tone[c], $sformatf("R3 ch%0d first low", c), len, exp);
          else if ((seg[c] % 2) == 1)
            chk(len == exp, $sformatf("R4 ch%0d high half", c), len, exp);
          else
            chk(len == exp, $sformatf("R5 R6 ch%0d low half", c), len, exp);
          last[c] = ticks;
          seg[c]++;
        end
      end
      prev = tone;
    end

    for (int c = 0; c < NCH; c++)
      chk(seg[c] == SEGS, $sformatf("R7 ch%0d edge count", c), seg[c], SEGS);
    chk(idle_bad == 0, "R2 changes on idle cycles", idle_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule